// File: doc/BRIEF.md
# Framebuffer Line Fill Engine

The block paints a run of consecutive framebuffer words with one 16-bit value. Software sets a fill length and a start address, then writes the fill value; that last write launches the fill. The engine then emits one memory write per clock on a word-wide write port until the run is done.

Addresses advance only in their low byte, so a run wraps inside one 256-word line and never crosses into the next line. When a run ends, the start register points at the word after the last one written, so a following fill continues where the previous one stopped. Writes always target the framebuffer page that is not on screen: the inverse of the displayed-page input, captured when the fill starts. While a fill runs, the block drops its ready output and ignores register writes, so the master must hold its request until ready returns.

Top module: `fb_fill_engine`

## Requirements
- R1: After reset, busy_o and mem_we_o are 0, reg_ready_o is 1, and len_o, start_o and data_o are all zero.
- R2: An accepted write with reg_sel_i = 0 loads len_o from reg_wdata_i[7:0]. An accepted write with reg_sel_i = 1 loads start_o from reg_wdata_i. Neither write starts a fill.
- R3: An accepted write with reg_sel_i = 2 loads data_o from reg_wdata_i and starts a fill. data_o keeps that value after the fill ends.
- R4: A fill asserts mem_we_o for exactly len_o+1 consecutive cycles, so it writes 1 to 256 words. The first write cycle is the cycle after the triggering write, and mem_wdata_o equals the fill value throughout.
- R5: The first write goes to the start address. After each word, only the low 8 address bits increment, modulo 256, and the high 8 bits stay constant.
- R6: When the fill ends, start_o equals the start high byte, with low byte (start low byte + len + 1) mod 256.
- R7: mem_page_o is the inverse of page_sel_i sampled at the triggering write, and it holds for the whole fill.
- R8: busy_o is 1 exactly while mem_we_o is 1. reg_ready_o is 0 while busy, and a register write presented while busy has no effect.
- R9: A write with reg_sel_i = 3 changes no register and starts no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write request |
| reg_sel_i | input | 2 | Register select: 0 length, 1 start, 2 data/trigger, 3 none |
| reg_wdata_i | input | 16 | Register write data |
| reg_ready_o | output | 1 | Write accepted this cycle when high |
| page_sel_i | input | 1 | Page currently displayed |
| len_o | output | 8 | Fill length register (words minus one) |
| start_o | output | 16 | Fill start / running address register |
| data_o | output | 16 | Fill data register |
| busy_o | output | 1 | Fill in progress |
| mem_we_o | output | 1 | Framebuffer write strobe |
| mem_page_o | output | 1 | Target framebuffer page |
| mem_addr_o | output | 16 | Framebuffer word address |
| mem_wdata_o | output | 16 | Framebuffer write data |

## Verification
Every cycle, the assertions check that the address steps in the low byte only with the high byte fixed, that data and page hold steady during a run, that a trigger produces a first write with the captured value, inverted page and start address, and that writes presented while busy leave the length and data registers alone. Only the bench scenarios can show the exact word count for each length, the final start pointer after a wrap, the continuation of back-to-back fills, and the reset state.

// File: rtl/fb_fill_pkg.sv
package fb_fill_pkg;
  typedef enum logic [1:0] {
    SEL_LEN   = 2'd0,
    SEL_START = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } fill_sel_e;
endpackage

// File: rtl/fb_fill_regs.sv
module fb_fill_regs
  import fb_fill_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LINE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  fill_sel_e            sel_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 step_i,
  output logic [LINE_BITS-1:0] len_o,
  output logic [ADDR_W-1:0]    start_o,
  output logic [DATA_W-1:0]    data_o
);
  logic [LINE_BITS-1:0] len_q;
  logic [ADDR_W-1:0]    start_q, start_nxt;
  logic [DATA_W-1:0]    data_q;

  // line-local increment: high part of the address never moves
  generate
    if (LINE_BITS >= ADDR_W) begin : g_full_inc
      assign start_nxt = start_q + {{(ADDR_W-1){1'b0}}, 1'b1};
    end else begin : g_line_inc
      logic [LINE_BITS-1:0] lo_nxt;
      assign lo_nxt    = start_q[LINE_BITS-1:0] + {{(LINE_BITS-1){1'b0}}, 1'b1};
      assign start_nxt = {start_q[ADDR_W-1:LINE_BITS], lo_nxt};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      start_q <= '0;
      data_q  <= '0;
    end else if (step_i) begin
      start_q <= start_nxt;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_LEN:   len_q   <= wdata_i[LINE_BITS-1:0];
        SEL_START: start_q <= wdata_i[ADDR_W-1:0];
        SEL_DATA:  data_q  <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign len_o   = len_q;
  assign start_o = start_q;
  assign data_o  = data_q;
endmodule

// File: rtl/fb_fill_ctrl.sv
module fb_fill_ctrl #(
  parameter int LINE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 trig_i,
  input  logic [LINE_BITS-1:0] len_i,
  input  logic                 page_sel_i,
  output logic                 busy_o,
  output logic                 page_o
);
  logic                 busy_q, page_q;
  logic [LINE_BITS-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      page_q <= 1'b0;
      left_q <= '0;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - {{(LINE_BITS-1){1'b0}}, 1'b1};
    end else if (trig_i) begin
      busy_q <= 1'b1;
      left_q <= len_i;
      page_q <= ~page_sel_i; // write the hidden page
    end
  end

  assign busy_o = busy_q;
  assign page_o = page_q;
endmodule

// File: rtl/fb_fill_engine.sv
module fb_fill_engine
  import fb_fill_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LINE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic                 reg_ready_o,
  input  logic                 page_sel_i,
  output logic [LINE_BITS-1:0] len_o,
  output logic [ADDR_W-1:0]    start_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 busy_o,
  output logic                 mem_we_o,
  output logic                 mem_page_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o
);
  fill_sel_e sel;
  logic      busy, accept, trig;

  assign sel    = fill_sel_e'(reg_sel_i);
  assign accept = reg_we_i && !busy;
  assign trig   = accept && (sel == SEL_DATA);

  fb_fill_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BITS(LINE_BITS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (accept),
    .sel_i   (sel),
    .wdata_i (reg_wdata_i),
    .step_i  (busy),
    .len_o   (len_o),
    .start_o (start_o),
    .data_o  (data_o)
  );

  fb_fill_ctrl #(.LINE_BITS(LINE_BITS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .len_i      (len_o),
    .page_sel_i (page_sel_i),
    .busy_o     (busy),
    .page_o     (mem_page_o)
  );

  assign reg_ready_o = !busy;
  assign busy_o      = busy;
  assign mem_we_o    = busy;
  assign mem_addr_o  = start_o; // start register doubles as running pointer
  assign mem_wdata_o = data_o;
endmodule

// File: rtl/fb_fill_chk.sv
module fb_fill_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LINE_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [1:0]           reg_sel_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic                 reg_ready_o,
  input logic                 page_sel_i,
  input logic [LINE_BITS-1:0] len_o,
  input logic [ADDR_W-1:0]    start_o,
  input logic [DATA_W-1:0]    data_o,
  input logic                 busy_o,
  input logic                 mem_we_o,
  input logic                 mem_page_o,
  input logic [ADDR_W-1:0]    mem_addr_o,
  input logic [DATA_W-1:0]    mem_wdata_o
);
  a_r3_trigger_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_ready_o && reg_sel_i == 2'd2) |=>
      (mem_we_o && mem_wdata_o == $past(reg_wdata_i) && mem_addr_o == $past(start_o)));

  a_r5_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (!mem_we_o ||
      (mem_addr_o[ADDR_W-1:LINE_BITS] == $past(mem_addr_o[ADDR_W-1:LINE_BITS]) &&
       mem_addr_o[LINE_BITS-1:0] == $past(mem_addr_o[LINE_BITS-1:0]) + 1'b1)));

  a_r7_page_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_ready_o && reg_sel_i == 2'd2) |=> (mem_page_o == !$past(page_sel_i)));

  a_r7_run_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (!mem_we_o || ($stable(mem_page_o) && $stable(mem_wdata_o))));

  a_r8_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i) |=> ($stable(len_o) && $stable(data_o)));
endmodule

bind fb_fill_engine fb_fill_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BITS(LINE_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .reg_wdata_i(reg_wdata_i), .reg_ready_o(reg_ready_o), .page_sel_i(page_sel_i),
  .len_o(len_o), .start_o(start_o), .data_o(data_o), .busy_o(busy_o),
  .mem_we_o(mem_we_o), .mem_page_o(mem_page_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/tb_fb_fill_engine.sv
module tb_fb_fill_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic        reg_ready;
  logic        page_sel = 1'b0;
  logic [7:0]  len;
  logic [15:0] start, data;
  logic        busy, mem_we, mem_page;
  logic [15:0] mem_addr, mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  fb_fill_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_ready_o(reg_ready), .page_sel_i(page_sel),
    .len_o(len), .start_o(start), .data_o(data), .busy_o(busy),
    .mem_we_o(mem_we), .mem_page_o(mem_page), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] next_start(input logic [15:0] s, input logic [7:0] l);
    logic [7:0] lo;
    lo = s[7:0] + l + 8'd1;
    return {s[15:8], lo};
  endfunction

  // drive at negedge, hold over one posedge, release at the next negedge
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fill(input logic [7:0] l, input logic [15:0] s, input logic [15:0] d,
                      input logic pg, input bit poke);
    logic [15:0] a;
    wr(2'd0, {8'hA5, l});
    chk(len == l, "R2 len load", len, l);
    chk(!busy, "R2 no fill on len", busy, 0);
    wr(2'd1, s);
    chk(start == s, "R2 start load", start, s);
    page_sel = pg;
    wr(2'd2, d);
    chk(data == d, "R3 data load", data, d);
    a = s;
    for (int i = 0; i <= int'(l); i++) begin
      chk(mem_we && busy, "R4 write strobe", {mem_we, busy}, 2'b11);
      chk(mem_addr == a, "R5 address", mem_addr, a);
      chk(mem_wdata == d, "R4 data", mem_wdata, d);
      chk(mem_page == !pg, "R7 page", mem_page, !pg);
      chk(!reg_ready, "R8 ready low", reg_ready, 0);
      if (poke && i == 0) begin
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0033;
        page_sel = !pg;
      end else begin
        reg_we = 1'b0;
      end
      a = {a[15:8], a[7:0] + 8'd1};
      @(posedge clk); @(negedge clk);
    end
    reg_we = 1'b0;
    chk(!mem_we && !busy, "R4 run length", {mem_we, busy}, 0);
    chk(reg_ready, "R8 ready back", reg_ready, 1);
    chk(start == next_start(s, l), "R6 end pointer", start, next_start(s, l));
    chk(data == d, "R3 data kept", data, d);
    chk(len == l, "R8 busy write ignored", len, l);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] s0;
    logic [7:0]  l0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && reg_ready, "R1 reset outputs", {busy, mem_we, reg_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we && reg_ready, "R1 after reset", {busy, mem_we, reg_ready}, 3'b001);
    chk(len == 0 && start == 0 && data == 0, "R1 registers zero", {len, start}, 0);

    // directed corners
    fill(8'd0,   16'h1234, 16'hBEEF, 1'b0, 1'b0); // single word
    fill(8'd3,   16'h40FE, 16'h0F0F, 1'b1, 1'b1); // wraps, poke while busy
    fill(8'd255, 16'h7780, 16'hFFFF, 1'b0, 1'b0); // full line
    // continuation: trigger again without reloading start
    s0 = start; l0 = len;
    wr(2'd2, 16'h5A5A);
    chk(mem_addr == s0 && mem_we, "R6 continue from end", mem_addr, s0);
    repeat (int'(l0) + 1) @(negedge clk);
    chk(start == next_start(s0, l0), "R6 second run end", start, next_start(s0, l0));

    // select 3 does nothing
    s0 = start; l0 = len;
    wr(2'd3, 16'hC3C3);
    chk(!busy && !mem_we, "R9 no fill", {busy, mem_we}, 0);
    chk(start == s0 && len == l0 && data == 16'h5A5A, "R9 no register change",
        data, 16'h5A5A);

    for (int k = 0; k < 24; k++) begin
      logic [7:0] rl;
      rl = 8'($urandom_range(0, 40));
      if (k % 6 == 5) rl = 8'($urandom_range(200, 255));
      fill(rl, 16'($urandom), 16'($urandom), 1'($urandom), (k % 3) == 0);
    end
    finish_run();
  end
endmodule